// File: doc/BRIEF.md
# Telephony Codec Serial Port

This block connects an 8-bit telephony codec to the chip. It drives the codec's bit clock and a frame sync pulse. It shifts bytes taken from a transmit queue out on a serial PCM line. It also gathers bits arriving on the serial input line into bytes and stores them in a receive queue. Software pushes outgoing bytes with a data write and pops incoming bytes with a data read. The block can raise an interrupt after every eight frames, which at the nominal rate means once per millisecond.

The serial rate comes from a one-cycle `bit_tick` strobe that the surrounding chip supplies at 64 kHz. Each frame is eight ticks long and carries one byte in each direction, which gives 8000 frames per second. Transmit and receive each have their own enable. A single frame-and-interrupt timebase runs while either enable is set, so the first interrupt is measured from whichever enable came on first. With both enables clear, the timebase and interrupt logic stay idle, and the status outputs make both queues look empty.

Top module: `codec_serial_port`

## Requirements
- R1: Each direction has its own 16-entry, 8-bit first-in first-out queue. Bytes leave the receive queue in the order in which they arrived. While the block is active, `tx_full` is 1 exactly when 16 bytes are waiting to be sent.
- R2: A frame is 8 bit ticks long. The bit tick that ends the last slot loads the next transmit byte. If the transmit queue is empty, or transmit is disabled, the loaded byte is 0x00. `pcm_out` then presents the byte's bits, most significant bit first, one bit per tick.
- R3: `pcm_fsync` is 1 during the last bit slot of each frame, which is the slot just before bit 7 of the next byte. This includes the waiting slot between enabling and the first tick. It is 0 in every other slot and whenever both enables are clear.
- R4: `pcm_in` is sampled on each bit tick that ends a slot, with the first sample taken as bit 7. When receive is enabled, the completed byte is pushed into the receive queue at the tick that ends the frame. If the receive queue is full, the byte is discarded.
- R5: With `irq_en` set, `irq` goes to 1 on the tick that completes every eighth frame. The count starts at the first enable. The first interrupt therefore follows the 65th tick after enabling. With `irq_en` clear, `irq` stays 0.
- R6: `irq` stays 1 until an `eoi` pulse clears it. If an `eoi` pulse falls in the same cycle as a new interrupt event, the interrupt wins.
- R7: While both enables are clear, the following hold. `irq` and the frame counters are held at zero. `rx_empty` reads 1 and `tx_full` reads 0. `rd_data` is 0x00 and a read removes nothing. Writes are still accepted into the transmit queue.
- R8: `pcm_out` is 0 whenever `tx_en` is 0.
- R9: A data write while the transmit queue holds 16 bytes is ignored.
- R10: A read while the receive queue is empty returns 0x00 and leaves the queue unchanged.
- R11: `pcm_clk` rises in the cycle after each bit tick and stays high for `CLK_HIGH` system cycles (2 by default). It is 0 while both enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at the serial bit rate |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Data write strobe (push into transmit queue) |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Data read strobe (pop from receive queue) |
| rd_data | output | 8 | Head of receive queue, 0x00 when empty or idle |
| eoi | input | 1 | End-of-interrupt strobe, clears `irq` |
| rx_empty | output | 1 | Receive queue empty (forced 1 when idle) |
| tx_full | output | 1 | Transmit queue full (forced 0 when idle) |
| irq | output | 1 | Sticky interrupt request |
| pcm_clk | output | 1 | Bit clock to the codec |
| pcm_fsync | output | 1 | Frame sync to the codec |
| pcm_out | output | 1 | Serial data to the codec |
| pcm_in | input | 1 | Serial data from the codec |

## Verification
Two things can land in the same system cycle: a software `eoi` and the frame-end tick that completes the sixteenth frame and sets the interrupt again. The bench provokes this by driving `eoi` and `bit_tick` together on that exact tick, with `irq` already high. It expects `irq` to stay 1, and then expects a lone `eoi` to clear it. A second overlap occurs when a frame-start pop and a software push hit a full transmit queue. It is checked by looping `pcm_out` back to `pcm_in` and comparing the received bytes against the written order.

// File: rtl/codec_pkg.sv
package codec_pkg;
    localparam int BYTE_W     = 8;
    localparam int SLOT_W     = $clog2(BYTE_W);
    localparam int IRQ_FRAMES = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/codec_fifo.sv
module codec_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rd;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW:0] count;
    logic do_push, do_pop;

    assign count   = ptr_q.wr - ptr_q.rd;
    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[ptr_q.rd[AW-1:0]];

    always_comb begin
        ptr_d = ptr_q;
        if (do_push) ptr_d.wr = ptr_q.wr + 1'b1;
        if (do_pop)  ptr_d.rd = ptr_q.rd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ptr_q.wr[AW-1:0]] <= wdata;
    end

    // R9: a push into a full queue must not move the write pointer
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (ptr_q.wr == $past(ptr_q.wr)));

    // R10: a pop from an empty queue must not move the read pointer
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (ptr_q.rd == $past(ptr_q.rd)));
endmodule

// File: rtl/codec_frame_timer.sv
module codec_frame_timer
    import codec_pkg::*;
#(
    parameter int CLK_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bit_tick,
    output logic in_frame,
    output logic bit_sample,
    output logic frame_load,
    output logic frame_end,
    output logic fsync,
    output logic pcm_clk
);
    localparam int CW = $clog2(CLK_HIGH + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              in_frame;
        logic              clk_hi;
        logic [CW-1:0]     hi_cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.slot     = LAST_SLOT;
            st_d.in_frame = 1'b0;
            st_d.clk_hi   = 1'b0;
            st_d.hi_cnt   = '0;
        end else if (bit_tick) begin
            st_d.slot     = st_q.slot + 1'b1;
            st_d.in_frame = 1'b1;
            st_d.clk_hi   = 1'b1;
            st_d.hi_cnt   = CW'(CLK_HIGH - 1);
        end else if (st_q.hi_cnt != '0) begin
            st_d.hi_cnt   = st_q.hi_cnt - 1'b1;
        end else begin
            st_d.clk_hi   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{slot: LAST_SLOT, in_frame: 1'b0, clk_hi: 1'b0, hi_cnt: '0};
        else        st_q <= st_d;
    end

    assign in_frame   = st_q.in_frame;
    assign bit_sample = active && bit_tick && st_q.in_frame;
    assign frame_load = active && bit_tick && (st_q.slot == LAST_SLOT);
    assign frame_end  = frame_load && st_q.in_frame;
    assign fsync      = active && (st_q.slot == LAST_SLOT);
    assign pcm_clk    = st_q.clk_hi;

    // R2: every tick while active advances the slot by one, modulo a frame
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_tick) |=> (!active || st_q.slot == SLOT_W'($past(st_q.slot) + 1'b1)));

    // R3: no frame sync while the timebase is idle
    assert_fsync_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !fsync);

    // R11: bit clock drops once the timebase goes idle
    assert_clk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pcm_clk);
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
    import codec_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_HIGH   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        tx_en,
    input  logic        rx_en,
    input  logic        irq_en,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic        eoi,
    output logic        rx_empty,
    output logic        tx_full,
    output logic        irq,
    output logic        pcm_clk,
    output logic        pcm_fsync,
    output logic        pcm_out,
    input  logic        pcm_in
);
    localparam int FCW = $clog2(IRQ_FRAMES);
    localparam logic [FCW-1:0] LAST_FRAME = FCW'(IRQ_FRAMES - 1);

    typedef struct packed {
        byte_t             tx_sh;
        logic [BYTE_W-2:0] rx_sh;
        logic [FCW-1:0]    frame_cnt;
        logic              irq;
    } port_t;

    port_t st_q, st_d;

    logic  active;
    logic  in_frame, bit_sample, frame_load, frame_end;
    logic  txf_empty, txf_full, rxf_empty, rxf_full;
    byte_t txf_head, rxf_head, rx_byte;
    logic  tx_pop, rx_push, rx_pop;

    assign active  = tx_en || rx_en;
    assign rx_byte = {st_q.rx_sh, pcm_in};
    assign tx_pop  = frame_load && tx_en;
    assign rx_push = frame_end && rx_en;
    assign rx_pop  = rd_en && active && !rxf_empty;

    codec_frame_timer #(.CLK_HIGH(CLK_HIGH)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .bit_tick   (bit_tick),
        .in_frame   (in_frame),
        .bit_sample (bit_sample),
        .frame_load (frame_load),
        .frame_end  (frame_end),
        .fsync      (pcm_fsync),
        .pcm_clk    (pcm_clk)
    );

    codec_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .pop   (tx_pop),
        .wdata (wr_data),
        .head  (txf_head),
        .empty (txf_empty),
        .full  (txf_full)
    );

    codec_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .pop   (rx_pop),
        .wdata (rx_byte),
        .head  (rxf_head),
        .empty (rxf_empty),
        .full  (rxf_full)
    );

    always_comb begin
        st_d = st_q;
        if (frame_load)
            st_d.tx_sh = (tx_en && !txf_empty) ? txf_head : '0;
        else if (bit_sample)
            st_d.tx_sh = st_q.tx_sh << 1;
        if (bit_sample)
            st_d.rx_sh = rx_byte[BYTE_W-2:0];
        if (eoi)
            st_d.irq = 1'b0;
        if (frame_end) begin
            st_d.frame_cnt = st_q.frame_cnt + 1'b1;
            if (st_q.frame_cnt == LAST_FRAME && irq_en)
                st_d.irq = 1'b1;
        end
        if (!active)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pcm_out  = tx_en && in_frame && st_q.tx_sh[BYTE_W-1];
    assign rd_data  = (active && !rxf_empty) ? rxf_head : '0;
    assign rx_empty = !active || rxf_empty;
    assign tx_full  = active && txf_full;
    assign irq      = st_q.irq;

    // R8: serial output silent with transmit disabled
    assert_pcm_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !pcm_out);

    // R6: interrupt holds until acknowledged
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi && active) |=> irq);

    // R7: idle clears the interrupt and masks the flags
    assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !irq);
    assert_idle_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (rx_empty && !tx_full && rd_data == 8'h00));

    // R4: a full receive queue is not overrun by the frame-end push
    assert_rx_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_full && rx_push && !rx_pop) |=> rxf_full);
endmodule

// File: tb/test_codec_serial_port.sv
module test_codec_serial_port;
    import codec_pkg::*;

    logic  clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
    logic  tx_en = 1'b0, rx_en = 1'b0, irq_en = 1'b0;
    logic  wr_en = 1'b0, rd_en = 1'b0, eoi = 1'b0;
    byte_t wr_data = '0;
    byte_t rd_data;
    logic  rx_empty, tx_full, irq, pcm_clk, pcm_fsync, pcm_out, pcm_in;
    int    n_chk = 0, n_bad = 0;
    bit    done = 1'b0;

    assign pcm_in = pcm_out;   // loopback
    always #4 clk = ~clk;      // 125 MHz

    codec_serial_port i_codec_serial_port (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .tx_en(tx_en), .rx_en(rx_en), .irq_en(irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .eoi(eoi), .rx_empty(rx_empty), .tx_full(tx_full), .irq(irq),
        .pcm_clk(pcm_clk), .pcm_fsync(pcm_fsync), .pcm_out(pcm_out), .pcm_in(pcm_in)
    );

    function automatic byte_t pat(int i);
        return byte_t'(i * 37 + 165);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_ticks(int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic write_byte(byte_t v);
        @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic read_byte(output byte_t v);
        @(negedge clk) begin v = rd_data; rd_en = 1'b1; end
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 rx_empty after reset", rx_empty, 1);
        chk("R7 tx_full after reset", tx_full, 0);
        chk("R7 irq after reset", irq, 0);
        chk("R3 fsync after reset", pcm_fsync, 0);
        chk("R8 pcm_out after reset", pcm_out, 0);
        chk("R11 pcm_clk after reset", pcm_clk, 0);
    endtask

    task automatic t_idle();
        byte_t v;
        for (int i = 0; i < 16; i++) write_byte(pat(i));
        chk("R7 tx_full masked while idle", tx_full, 0);
        chk("R7 rx_empty masked while idle", rx_empty, 1);
        read_byte(v);
        chk("R7 idle read data", v, 8'h00);
        run_ticks(3);
        chk("R3 fsync idle", pcm_fsync, 0);
        chk("R11 pcm_clk idle", pcm_clk, 0);
    endtask

    task automatic t_stream();
        byte_t v;
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        chk("R1 tx_full at 16 entries", tx_full, 1);
        chk("R3 fsync in waiting slot", pcm_fsync, 1);
        write_byte(8'hEE);              // R9: must be dropped
        chk("R9 tx_full after ignored write", tx_full, 1);
        @(negedge clk) rx_en = 1'b1;
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        chk("R11 pcm_clk high 1", pcm_clk, 1);
        chk("R3 fsync low in slot 0", pcm_fsync, 0);
        chk("R2 first bit is MSB", pcm_out, pat(0)[7]);
        chk("R1 tx_full after frame pop", tx_full, 0);
        @(negedge clk) chk("R11 pcm_clk high 2", pcm_clk, 1);
        @(negedge clk) chk("R11 pcm_clk low", pcm_clk, 0);
        write_byte(8'h77);
        chk("R1 tx_full refilled", tx_full, 1);
        run_ticks(1);
        chk("R2 second bit", pcm_out, pat(0)[6]);
        run_ticks(6);
        chk("R3 fsync in last slot", pcm_fsync, 1);
        run_ticks(1);
        chk("R3 fsync drops at frame start", pcm_fsync, 0);
        run_ticks(128);                 // 137 ticks, 17 frames done
        chk("R5 irq stays low when disabled", irq, 0);
        chk("R4 rx holds data", rx_empty, 0);
        for (int i = 0; i < 16; i++) begin
            read_byte(v);
            chk($sformatf("R1 rx order byte %0d", i), v, pat(i));
        end
        chk("R4 17th byte discarded on full", rx_empty, 1);
        read_byte(v);
        chk("R10 empty read data", v, 8'h00);
        chk("R10 empty read leaves queue empty", rx_empty, 1);
        run_ticks(8);
        read_byte(v);
        chk("R2 empty queue sends zero", v, 8'h00);
        chk("R10 queue drained", rx_empty, 1);
    endtask

    task automatic t_irq();
        @(negedge clk) begin tx_en = 1'b0; rx_en = 1'b0; end
        @(negedge clk);
        chk("R7 irq idle", irq, 0);
        @(negedge clk) begin rx_en = 1'b1; irq_en = 1'b1; end
        run_ticks(64);
        chk("R5 irq before 8th frame", irq, 0);
        run_ticks(1);
        chk("R5 irq at 8th frame", irq, 1);
        write_byte(8'hFF);
        @(negedge clk) tx_en = 1'b1;
        run_ticks(8);
        chk("R2 loaded byte on pcm_out", pcm_out, 1);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        chk("R8 pcm_out gated", pcm_out, 0);
        chk("R6 irq sticky", irq, 1);
        run_ticks(55);
        @(negedge clk) begin eoi = 1'b1; bit_tick = 1'b1; end
        @(negedge clk) begin eoi = 1'b0; bit_tick = 1'b0; end
        chk("R6 set wins over eoi", irq, 1);
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
        chk("R6 eoi clears", irq, 0);
        run_ticks(63);
        chk("R5 irq before 24th frame", irq, 0);
        run_ticks(1);
        chk("R5 irq at 24th frame", irq, 1);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        chk("R7 irq cleared on idle", irq, 0);
        chk("R7 rx_empty masked with data", rx_empty, 1);
        chk("R7 tx_full masked", tx_full, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_stream();
        t_irq();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule